// File: doc/BRIEF.md
# Palette Grayscale Conversion Engine

This block walks a contiguous range of palette entries and replaces each red/green/blue triple with one luminance value. Software gives a first index, an entry count and a one-cycle start strobe. The engine then reads each entry through a simple synchronous read/write port. It weights the three components with integer luminance coefficients, rounds the result, clamps it to the 6-bit colour range and writes the gray value back to all three components of the same entry.

While a run is in progress the engine holds a screen-blank request high, so the display never shows a half-converted palette. A range that would run past the last palette entry is cut short at that entry. A zero count finishes at once, without touching memory.

Top module: `pal_gray_engine`

## Requirements
- R1: A run started with first index S and count N (S + N at most 256) rewrites entries S through S+N-1 and leaves every other entry unchanged.
- R2: `blank_o` is high on every cycle that `busy_o` is high, including the cycle of each memory access, and low whenever the engine is idle.
- R3: Each palette word holds red in bits [23:16], green in [15:8] and blue in [7:0]. Before clamping, the gray value is (77*R + 151*G + 28*B + 128) >> 8.
- R4: A gray value above 63 is written as 63.
- R5: The gray value is written to the red, green and blue fields of the entry that was read.
- R6: Each entry takes three cycles: a read strobe, a compute cycle, then a write strobe to the same address. A run of N entries keeps `busy_o` high for exactly 3*N cycles.
- R7: A start with count 0 raises `done_o` on the next cycle. It raises neither `busy_o` nor `blank_o` and issues no memory access.
- R8: Entries beyond index 255 are never processed. A run from S with S + N above 256 handles S through 255 only, taking 3*(256-S) cycles, and does not wrap to index 0.
- R9: A start strobe while `busy_o` is high is ignored. The run in progress is not altered, and no entries named by the ignored start are touched.
- R10: `done_o` is a one-cycle pulse in the cycle after the last write, with `busy_o` already low.
- R11: After reset, `busy_o`, `done_o`, `blank_o`, `mem_re_o` and `mem_we_o` are all low.
- R12: A start at index 0 with count 256 converts every palette entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| first_idx_i | input | 8 | First palette index of the run |
| num_i | input | 9 | Number of entries (0 to 256) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| blank_o | output | 1 | Screen-blank request |
| mem_addr_o | output | 8 | Palette address |
| mem_re_o | output | 1 | Read strobe; data is expected on the next cycle |
| mem_rdata_i | input | 24 | Read data {R,G,B} |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 24 | Write data {gray,gray,gray} |

## Verification
The hardest conditions to reach from the ports are a start strobe that arrives in the middle of a run, and a range that runs off the end of the palette. Both are silent when handled correctly. The bench fills the whole palette model with a known per-index pattern and issues a second start with a different range partway through a run. It then compares every one of the 256 entries, so a wrap to index 0 or a hijacked range shows up as a changed entry outside the expected window. The clamp is reached with 8-bit component values whose weighted sum exceeds the 6-bit range.

// File: rtl/pal_gray_pkg.sv
package pal_gray_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE
  } pg_state_e;

  localparam int unsigned W_RED   = 77;
  localparam int unsigned W_GREEN = 151;
  localparam int unsigned W_BLUE  = 28;
  localparam int unsigned W_SHIFT = 8;
  localparam int unsigned W_ROUND = 1 << (W_SHIFT - 1);
endpackage

// File: rtl/pal_gray_luma.sv
module pal_gray_luma #(
  parameter int COMP_W = 8,
  parameter int GRAY_W = 6
) (
  input  logic [3*COMP_W-1:0] rgb_i,
  output logic [COMP_W-1:0]   gray_o
);
  import pal_gray_pkg::*;

  localparam int SUM_W = COMP_W + 10;
  localparam logic [SUM_W-1:0] GMAX = SUM_W'((1 << GRAY_W) - 1);

  logic [SUM_W-1:0] r_w, g_w, b_w, sum_w, scaled_w;

  assign r_w = SUM_W'(rgb_i[3*COMP_W-1 -: COMP_W]);
  assign g_w = SUM_W'(rgb_i[2*COMP_W-1 -: COMP_W]);
  assign b_w = SUM_W'(rgb_i[COMP_W-1 -: COMP_W]);

  always_comb begin
    sum_w    = r_w * SUM_W'(W_RED) + g_w * SUM_W'(W_GREEN)
             + b_w * SUM_W'(W_BLUE) + SUM_W'(W_ROUND);
    scaled_w = sum_w >> W_SHIFT;
    gray_o   = (scaled_w > GMAX) ? GMAX[COMP_W-1:0] : scaled_w[COMP_W-1:0];
  end
endmodule

// File: rtl/pal_gray_span.sv
module pal_gray_span #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] first_idx_i,
  input  logic [IDX_W:0]   num_i,
  output logic [IDX_W:0]   eff_o
);
  localparam int CNT_W = IDX_W + 1;
  localparam int DEPTH = 1 << IDX_W;

  logic [CNT_W-1:0] room_w;

  // entries left before the end of the palette
  assign room_w = CNT_W'(DEPTH) - CNT_W'(first_idx_i);
  assign eff_o  = (num_i > room_w) ? room_w : num_i;
endmodule

// File: rtl/pal_gray_ctrl.sv
module pal_gray_ctrl #(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] first_idx_i,
  input  logic [IDX_W:0]   eff_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] addr_o,
  output logic             re_o,
  output logic             calc_o,
  output logic             we_o
);
  import pal_gray_pkg::*;

  pg_state_e        state_q;
  logic [IDX_W:0]   left_q;
  logic [IDX_W-1:0] addr_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (eff_i == '0) begin
              done_q <= 1'b1;
            end else begin
              addr_q  <= first_idx_i;
              left_q  <= eff_i;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ:  state_q <= ST_CALC;
        ST_CALC:  state_q <= ST_WRITE;
        ST_WRITE: begin
          if (left_q == (IDX_W+1)'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            left_q  <= left_q - 1'b1;
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign addr_o = addr_q;
  assign re_o   = (state_q == ST_READ);
  assign calc_o = (state_q == ST_CALC);
  assign we_o   = (state_q == ST_WRITE);
endmodule

// File: rtl/pal_gray_engine.sv
module pal_gray_engine #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int GRAY_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    first_idx_i,
  input  logic [IDX_W:0]      num_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                blank_o,
  output logic [IDX_W-1:0]    mem_addr_o,
  output logic                mem_re_o,
  input  logic [3*COMP_W-1:0] mem_rdata_i,
  output logic                mem_we_o,
  output logic [3*COMP_W-1:0] mem_wdata_o
);
  logic [IDX_W:0]    eff_w;
  logic              calc_w;
  logic [COMP_W-1:0] gray_w, gray_q;

  pal_gray_span #(.IDX_W(IDX_W)) u_span (
    .first_idx_i (first_idx_i),
    .num_i       (num_i),
    .eff_o       (eff_w)
  );

  pal_gray_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .first_idx_i (first_idx_i),
    .eff_i       (eff_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .addr_o      (mem_addr_o),
    .re_o        (mem_re_o),
    .calc_o      (calc_w),
    .we_o        (mem_we_o)
  );

  pal_gray_luma #(.COMP_W(COMP_W), .GRAY_W(GRAY_W)) u_luma (
    .rgb_i  (mem_rdata_i),
    .gray_o (gray_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gray_q <= '0;
    else if (calc_w) gray_q <= gray_w;
  end

  assign mem_wdata_o = {3{gray_q}};
  assign blank_o     = busy_o;
endmodule

// File: rtl/pal_gray_engine_chk.sv
module pal_gray_engine_chk #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int GRAY_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                busy_o,
  input logic                done_o,
  input logic                blank_o,
  input logic [IDX_W-1:0]    mem_addr_o,
  input logic                mem_re_o,
  input logic                mem_we_o,
  input logic [3*COMP_W-1:0] mem_wdata_o
);
  localparam logic [COMP_W-1:0] GMAX = COMP_W'((1 << GRAY_W) - 1);

  // R2
  access_blanked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |-> blank_o);

  // R6
  read_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (!mem_re_o && !mem_we_o));

  // R6
  read_then_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> ##1 (mem_we_o && mem_addr_o == $past(mem_addr_o, 2)));

  // R4
  gray_clamped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o[COMP_W-1:0] <= GMAX));

  // R5
  gray_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o[3*COMP_W-1 -: COMP_W] == mem_wdata_o[COMP_W-1:0]
              && mem_wdata_o[2*COMP_W-1 -: COMP_W] == mem_wdata_o[COMP_W-1:0]));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o ##1 !done_o));
endmodule

bind pal_gray_engine pal_gray_engine_chk #(
  .IDX_W(IDX_W), .COMP_W(COMP_W), .GRAY_W(GRAY_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .blank_o     (blank_o),
  .mem_addr_o  (mem_addr_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/pal_gray_engine_tb.sv
module pal_gray_engine_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  first_idx_i = '0;
  logic [8:0]  num_i = '0;
  logic        busy_o, done_o, blank_o, mem_re_o, mem_we_o;
  logic [7:0]  mem_addr_o;
  logic [23:0] mem_rdata_i, mem_wdata_o;

  logic [23:0] mem [256];
  logic [23:0] orig [256];
  logic        pre_we = 1'b0;
  logic [7:0]  pre_addr = '0;
  logic [23:0] pre_data = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10ns clk_i = ~clk_i;

  pal_gray_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .first_idx_i(first_idx_i), .num_i(num_i),
    .busy_o(busy_o), .done_o(done_o), .blank_o(blank_o),
    .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
    .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (pre_we) mem[pre_addr] <= pre_data;
    else if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
  end

  // {rgb, expected gray}
  localparam logic [31:0] VEC [12] = '{
    {24'h000000, 8'd0},  {24'h3f3f3f, 8'd63}, {24'hffffff, 8'd63},
    {24'h0a141e, 8'd18}, {24'h3f0000, 8'd19}, {24'h003f00, 8'd37},
    {24'h00003f, 8'd7},  {24'h640000, 8'd30}, {24'h010101, 8'd1},
    {24'h000100, 8'd1},  {24'h010000, 8'd0},  {24'h808080, 8'd63}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_gray(input logic [23:0] v);
    int s;
    s = (77 * v[23:16] + 151 * v[15:8] + 28 * v[7:0] + 128) >> 8;
    return (s > 63) ? 8'd63 : 8'(s);
  endfunction

  task automatic put(input int idx, input logic [23:0] v);
    pre_we = 1'b1; pre_addr = 8'(idx); pre_data = v;
    @(negedge clk_i);
    pre_we = 1'b0;
  endtask

  task automatic fill_all();
    for (int i = 0; i < 256; i++) put(i, {8'(i), 8'(~i), 8'(i) ^ 8'h5a});
    for (int i = 0; i < 256; i++) orig[i] = mem[i];
  endtask

  // run S/N; optionally pulse a second start at busy cycle intr_at
  task automatic run(input int s, input int n, input int intr_at,
                     input int s2, input int n2,
                     output int busy_cnt, output int bad_blank,
                     output int stray, output int done_next);
    int guard;
    busy_cnt = 0; bad_blank = 0; stray = 0; guard = 0;
    for (int i = 0; i < 256; i++) orig[i] = mem[i];
    start_i = 1'b1; first_idx_i = 8'(s); num_i = 9'(n);
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && guard < 2000) begin
      if (busy_o) busy_cnt++;
      if (blank_o != busy_o) bad_blank++;
      if (!busy_o && (mem_re_o || mem_we_o)) stray++;
      if (intr_at >= 0 && busy_cnt == intr_at) begin
        start_i = 1'b1; first_idx_i = 8'(s2); num_i = 9'(n2);
      end else begin
        start_i = 1'b0;
      end
      guard++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    if (busy_o || blank_o) bad_blank++;
    @(negedge clk_i);
    done_next = done_o;
  endtask

  function automatic int mem_mismatch(input int s, input int e);
    for (int i = 0; i < 256; i++) begin
      logic [23:0] exp;
      exp = (i >= s && i <= e) ? {3{ref_gray(orig[i])}} : orig[i];
      if (mem[i] !== exp) return i;
    end
    return -1;
  endfunction

  initial begin
    int bc, bb, st, dn, mm;
    #1ns;
    // R11
    chk(!busy_o && !done_o && !blank_o && !mem_re_o && !mem_we_o,
        "R11", "idle outputs in reset", int'({busy_o, done_o, blank_o, mem_re_o, mem_we_o}), 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !blank_o, "R11", "idle after reset",
        int'({busy_o, done_o, blank_o}), 0);

    fill_all();

    // vector table: single-entry runs (R3 R4 R5 R6)
    for (int k = 0; k < 12; k++) begin
      put(32 + k, VEC[k][31:8]);
      run(32 + k, 1, -1, 0, 0, bc, bb, st, dn);
      chk(mem[32 + k] === {3{VEC[k][7:0]}}, "R3/R4/R5", $sformatf("vector %0d gray", k),
          int'(mem[32 + k][7:0]), int'(VEC[k][7:0]));
      chk(bc == 3, "R6", "cycles for one entry", bc, 3);
    end

    // multi-entry range R1 R2 R10
    run(100, 10, -1, 0, 0, bc, bb, st, dn);
    mm = mem_mismatch(100, 109);
    chk(mm < 0, "R1", "range 100..109 memory", mm, -1);
    chk(bc == 30, "R6", "busy cycles for 10 entries", bc, 30);
    chk(bb == 0 && st == 0, "R2", "blank follows busy", bb + st, 0);
    chk(dn == 0, "R10", "done lasts one cycle", dn, 0);

    // zero count R7
    for (int i = 0; i < 256; i++) orig[i] = mem[i];
    start_i = 1'b1; first_idx_i = 8'd5; num_i = 9'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o && !busy_o && !blank_o && !mem_re_o && !mem_we_o, "R7",
        "zero count done next cycle", int'({done_o, busy_o, blank_o}), 4);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R7", "zero count stays idle", int'({done_o, busy_o}), 0);
    mm = mem_mismatch(1, 0);
    chk(mm < 0, "R7", "zero count leaves memory", mm, -1);

    // end of palette R8
    run(250, 20, -1, 0, 0, bc, bb, st, dn);
    mm = mem_mismatch(250, 255);
    chk(mm < 0, "R8", "clip at 255, no wrap", mm, -1);
    chk(bc == 18, "R8", "busy cycles clipped run", bc, 18);

    // start while busy R9
    run(60, 4, 5, 180, 6, bc, bb, st, dn);
    mm = mem_mismatch(60, 63);
    chk(mm < 0, "R9", "second start ignored", mm, -1);
    chk(bc == 12, "R9", "run length unchanged", bc, 12);

    // full palette R12
    fill_all();
    run(0, 256, -1, 0, 0, bc, bb, st, dn);
    mm = mem_mismatch(0, 255);
    chk(mm < 0, "R12", "full palette converted", mm, -1);
    chk(bc == 768, "R12", "full palette cycles", bc, 768);
    chk(bb == 0 && st == 0, "R2", "blank over full run", bb + st, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule